// File: doc/BRIEF.md
# Banked Register File Addressing Unit

This block is the data-memory access path of a small 8-bit microcontroller core. Each access carries a 7-bit register field taken from an instruction. A direct access joins that field to the two bank-select bits of the status register to form a 9-bit data address. An access to the window register at field 0x00 is indirect. It takes nothing from the field. It forms the address from the high-indirect bit of the status register and the 8-bit pointer register, then reads or writes the location that address selects.

The unit holds the general-purpose byte array and three special locations: the status register, the pointer register and the window. These three sit at the same offsets in every bank. The general-purpose bytes alias between banks 0 and 1. Every other address returns zero and discards writes. A read result and the assembled address come back one clock after the access is presented.

Top module: `banked_regfile`

## Requirements
- R1: After synchronous reset, `rd_valid` is 0, `eff_addr` is 0x000 and `rd_data` is 0x00. The status and pointer registers both read back 0x00.
- R2: A direct access (field not 0x00) uses the address {status[6:5], field}. Status bits 6:5 are the bank number and form address bits 8:7.
- R3: An access with field 0x00 is indirect. Its address is {status[7], pointer[7:0]}, so pointer bit 7 forms address bit 7.
- R4: A read of the window returns the byte at the indirect address. A write to the window stores into that location, including the status and pointer registers.
- R5: Offsets 0x0C to 0x4F hold 68 general-purpose bytes. Offset n in bank 1 reaches the same byte as offset n in bank 0.
- R6: The status register (offset 0x03) and the pointer register (offset 0x04) are 8-bit read/write registers. They are reachable at those offsets in all four banks.
- R7: An indirect access whose pointer has offset 0x00 (it points at the window itself) reads 0x00, and a write through it changes nothing.
- R8: All other addresses read 0x00 and ignore writes. This covers the unused special offsets 0x01, 0x02 and 0x05 to 0x0B, offsets 0x50 to 0x7F, and general-purpose offsets in banks 2 and 3.
- R9: `rd_valid` and the result of an access appear on the clock edge after the one that samples `acc_en`. The returned data is the value held before any write made by that same access (read-first).
- R10: A write to the status register changes the bank used by the next access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_en | input | 1 | Access request this cycle |
| acc_wr | input | 1 | 1 = write `acc_wdata`, 0 = read only |
| acc_field | input | 7 | Register field from the instruction |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read result of the previous access (0x00 when none) |
| rd_valid | output | 1 | High the cycle after an access |
| eff_addr | output | 9 | Assembled 9-bit address of the most recent access |

## Verification
Every result is due exactly one clock after the edge that takes the access: `rd_valid`, `rd_data` and `eff_addr` all come from that single register stage. A register or array write takes effect on the same edge. Its effect, including a changed bank or pointer, shows up in the next access. The bench drives each access on a falling edge, holds it across one rising edge, and samples all three outputs on the following falling edge. Each read-first and alias check therefore sees the one edge it predicts.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  // Kind of storage an assembled address lands on
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_STAT = 2'd1,
    TGT_PTR  = 2'd2,
    TGT_GPR  = 2'd3
  } tgt_e;
endpackage

// File: rtl/rf_addr_decode.sv
module rf_addr_decode
  import regfile_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FIELD_W     = 7,
  parameter int WIN_OFS     = 0,
  parameter int STAT_OFS    = 3,
  parameter int PTR_OFS     = 4,
  parameter int GPR_FIRST   = 12,
  parameter int GPR_LAST    = 79,
  parameter int ALIAS_BANKS = 2,
  parameter int IRP_BIT     = 7,
  parameter int BANK_LO     = 5,
  localparam int BANK_W     = 2,
  localparam int ADDR_W     = FIELD_W + BANK_W,
  localparam int GPR_DEPTH  = GPR_LAST - GPR_FIRST + 1,
  localparam int RAM_AW     = $clog2(GPR_DEPTH)
) (
  input  logic [FIELD_W-1:0] field,
  input  logic [DATA_W-1:0]  status,
  input  logic [FIELD_W:0]   ptr,
  output logic [ADDR_W-1:0]  addr,
  output tgt_e               tgt,
  output logic [RAM_AW-1:0]  ram_idx
);
  logic               indirect;
  logic [FIELD_W-1:0] ofs;
  logic [BANK_W-1:0]  bank;
  logic               bank_ok;
  logic               in_gpr;
  logic [FIELD_W-1:0] gpr_off;

  assign indirect = (field == FIELD_W'(WIN_OFS));
  assign addr     = indirect ? {status[IRP_BIT], ptr}
                             : {status[BANK_LO+BANK_W-1:BANK_LO], field};
  assign ofs      = addr[FIELD_W-1:0];
  assign bank     = addr[ADDR_W-1:FIELD_W];

  // Bank filter only exists when some banks carry no alias of the array
  generate
    if (ALIAS_BANKS >= (1 << BANK_W)) begin : g_all_banks
      assign bank_ok = 1'b1;
    end else begin : g_some_banks
      assign bank_ok = (int'(bank) < ALIAS_BANKS);
    end
  endgenerate

  assign in_gpr  = (ofs >= FIELD_W'(GPR_FIRST)) && (ofs <= FIELD_W'(GPR_LAST)) && bank_ok;
  assign gpr_off = ofs - FIELD_W'(GPR_FIRST);
  assign ram_idx = gpr_off[RAM_AW-1:0];

  always_comb begin
    if (ofs == FIELD_W'(WIN_OFS))       tgt = TGT_NONE;  // window aimed at itself
    else if (ofs == FIELD_W'(STAT_OFS)) tgt = TGT_STAT;
    else if (ofs == FIELD_W'(PTR_OFS))  tgt = TGT_PTR;
    else if (in_gpr)                    tgt = TGT_GPR;
    else                                tgt = TGT_NONE;
  end
endmodule

// File: rtl/rf_special_regs.sv
module rf_special_regs #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stat,
  input  logic              wr_ptr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] status_q,
  output logic [PTR_W-1:0]  ptr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      ptr_q    <= '0;
    end else begin
      if (wr_stat) status_q <= wdata;
      if (wr_ptr)  ptr_q    <= wdata[PTR_W-1:0];
    end
  end
endmodule

// File: rtl/rf_gpr_ram.sv
module rf_gpr_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 68,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              re,
  input  logic              we,
  input  logic [AW-1:0]     idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [0:DEPTH-1];

  // Single port, read-first, no reset: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata <= mem[idx];
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regfile_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FIELD_W     = 7,
  parameter int WIN_OFS     = 0,
  parameter int STAT_OFS    = 3,
  parameter int PTR_OFS     = 4,
  parameter int GPR_FIRST   = 12,
  parameter int GPR_LAST    = 79,
  parameter int ALIAS_BANKS = 2,
  parameter int IRP_BIT     = 7,
  parameter int BANK_LO     = 5,
  localparam int ADDR_W     = FIELD_W + 2,
  localparam int PTR_W      = FIELD_W + 1,
  localparam int GPR_DEPTH  = GPR_LAST - GPR_FIRST + 1,
  localparam int RAM_AW     = $clog2(GPR_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_en,
  input  logic               acc_wr,
  input  logic [FIELD_W-1:0] acc_field,
  input  logic [DATA_W-1:0]  acc_wdata,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid,
  output logic [ADDR_W-1:0]  eff_addr
);
  logic [DATA_W-1:0] status_q;
  logic [PTR_W-1:0]  fsr_q;
  logic [ADDR_W-1:0] addr;
  tgt_e              tgt;
  logic [RAM_AW-1:0] ram_idx;
  logic              do_wr;
  logic [DATA_W-1:0] ram_q;

  tgt_e              tgt_q;
  logic [DATA_W-1:0] snap_q;
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;

  rf_addr_decode #(
    .DATA_W(DATA_W), .FIELD_W(FIELD_W), .WIN_OFS(WIN_OFS), .STAT_OFS(STAT_OFS),
    .PTR_OFS(PTR_OFS), .GPR_FIRST(GPR_FIRST), .GPR_LAST(GPR_LAST),
    .ALIAS_BANKS(ALIAS_BANKS), .IRP_BIT(IRP_BIT), .BANK_LO(BANK_LO)
  ) u_dec (
    .field   (acc_field),
    .status  (status_q),
    .ptr     (fsr_q),
    .addr    (addr),
    .tgt     (tgt),
    .ram_idx (ram_idx)
  );

  assign do_wr = acc_en && acc_wr;

  rf_special_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_spec (
    .clk      (clk),
    .rst      (rst),
    .wr_stat  (do_wr && (tgt == TGT_STAT)),
    .wr_ptr   (do_wr && (tgt == TGT_PTR)),
    .wdata    (acc_wdata),
    .status_q (status_q),
    .ptr_q    (fsr_q)
  );

  rf_gpr_ram #(.DATA_W(DATA_W), .DEPTH(GPR_DEPTH)) u_ram (
    .clk   (clk),
    .re    (acc_en && (tgt == TGT_GPR)),
    .we    (do_wr && (tgt == TGT_GPR)),
    .idx   (ram_idx),
    .wdata (acc_wdata),
    .rdata (ram_q)
  );

  // Response stage: captures the pre-write view of the selected location
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      tgt_q   <= TGT_NONE;
      snap_q  <= '0;
      addr_q  <= '0;
    end else begin
      valid_q <= acc_en;
      tgt_q   <= acc_en ? tgt : TGT_NONE;
      if (acc_en) begin
        addr_q <= addr;
        snap_q <= (tgt == TGT_STAT) ? status_q : DATA_W'(fsr_q);
      end
    end
  end

  always_comb begin
    unique case (tgt_q)
      TGT_GPR:          rd_data = ram_q;
      TGT_STAT, TGT_PTR: rd_data = snap_q;
      default:          rd_data = '0;
    endcase
  end

  assign rd_valid = valid_q;
  assign eff_addr = addr_q;
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int DATA_W   = 8,
  parameter int FIELD_W  = 7,
  parameter int WIN_OFS  = 0,
  parameter int GPR_LAST = 79,
  parameter int IRP_BIT  = 7,
  parameter int BANK_LO  = 5,
  localparam int ADDR_W  = FIELD_W + 2
) (
  input logic               clk,
  input logic               rst,
  input logic               acc_en,
  input logic [FIELD_W-1:0] acc_field,
  input logic [DATA_W-1:0]  rd_data,
  input logic               rd_valid,
  input logic [ADDR_W-1:0]  eff_addr,
  input logic [DATA_W-1:0]  status_q,
  input logic [FIELD_W:0]   fsr_q
);
  p_resp_follows_r9: assert property (@(posedge clk) disable iff (rst)
    acc_en |=> rd_valid);

  p_no_spurious_resp_r9: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> !rd_valid);

  p_direct_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_field != FIELD_W'(WIN_OFS)) |=>
      eff_addr == {$past(status_q[BANK_LO+1:BANK_LO]), $past(acc_field)});

  p_indirect_addr_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_field == FIELD_W'(WIN_OFS)) |=>
      eff_addr == {$past(status_q[IRP_BIT]), $past(fsr_q)});

  p_self_window_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && eff_addr[FIELD_W-1:0] == FIELD_W'(WIN_OFS)) |-> rd_data == '0);

  p_high_offsets_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && eff_addr[FIELD_W-1:0] > FIELD_W'(GPR_LAST)) |-> rd_data == '0);

  p_status_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> $stable(status_q) && $stable(fsr_q));
endmodule

bind banked_regfile banked_regfile_chk #(
  .DATA_W(DATA_W), .FIELD_W(FIELD_W), .WIN_OFS(WIN_OFS),
  .GPR_LAST(GPR_LAST), .IRP_BIT(IRP_BIT), .BANK_LO(BANK_LO)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_en    (acc_en),
  .acc_field (acc_field),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .eff_addr  (eff_addr),
  .status_q  (status_q),
  .fsr_q     (fsr_q)
);

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_en = 1'b0;
  logic       acc_wr = 1'b0;
  logic [6:0] acc_field = '0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic [8:0] eff_addr;

  int checks = 0;
  int failures = 0;
  logic [7:0] got_d;
  logic [8:0] got_a;
  logic       got_v;

  always #5 clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_field(acc_field), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .eff_addr(eff_addr)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  // One access: present on a falling edge, sample one clock later
  task automatic acc(input logic wr, input logic [6:0] f, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_field = f; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
    got_d = rd_data; got_a = eff_addr; got_v = rd_valid;
  endtask

  task automatic t_reset;
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 eff_addr", eff_addr, 0);
    chk("R1 rd_data", rd_data, 0);
    acc(0, 7'h03, 0); chk("R1 status", got_d, 8'h00);
    acc(0, 7'h04, 0); chk("R1 pointer", got_d, 8'h00);
  endtask

  task automatic t_direct;
    acc(1, 7'h20, 8'hA5); chk("R2 bank0 addr", got_a, 9'h020);
    acc(1, 7'h03, 8'h20);                                   // bank 1
    acc(1, 7'h21, 8'h5A); chk("R10 bank1 addr", got_a, 9'h0A1);
    acc(0, 7'h20, 0);     chk("R5 alias read", got_d, 8'hA5);
    chk("R2 bank1 addr", got_a, 9'h0A0);
    acc(1, 7'h03, 8'h40);                                   // bank 2
    acc(0, 7'h20, 0);     chk("R8 bank2 read", got_d, 0);
    chk("R2 bank2 addr", got_a, 9'h120);
    acc(1, 7'h20, 8'hFF);
    acc(1, 7'h03, 8'h00);                                   // bank 0
    acc(0, 7'h20, 0);     chk("R8 bank2 write ignored", got_d, 8'hA5);
    acc(0, 7'h21, 0);     chk("R5 bank1 write seen in bank0", got_d, 8'h5A);
    acc(1, 7'h0C, 8'h3C); acc(1, 7'h4F, 8'hF4);
    acc(0, 7'h0C, 0);     chk("R5 first byte", got_d, 8'h3C);
    acc(0, 7'h4F, 0);     chk("R5 last byte", got_d, 8'hF4);
    acc(1, 7'h50, 8'h77); acc(0, 7'h50, 0); chk("R8 offset 0x50", got_d, 0);
    acc(1, 7'h0B, 8'h77); acc(0, 7'h0B, 0); chk("R8 offset 0x0B", got_d, 0);
    acc(1, 7'h01, 8'h77); acc(0, 7'h01, 0); chk("R8 offset 0x01", got_d, 0);
  endtask

  task automatic t_indirect;
    acc(1, 7'h04, 8'h30);
    acc(1, 7'h00, 8'h77); chk("R3 indirect addr", got_a, 9'h030);
    acc(0, 7'h30, 0);     chk("R4 window write", got_d, 8'h77);
    acc(1, 7'h04, 8'hB1);
    acc(1, 7'h00, 8'h66); chk("R3 ptr bit7 addr", got_a, 9'h0B1);
    acc(0, 7'h31, 0);     chk("R4 R5 window bank1 alias", got_d, 8'h66);
    acc(0, 7'h00, 0);     chk("R4 window read", got_d, 8'h66);
    acc(1, 7'h03, 8'h80); acc(1, 7'h04, 8'h31);
    acc(0, 7'h00, 0);     chk("R3 high bit addr", got_a, 9'h131);
    chk("R8 indirect bank2", got_d, 0);
    acc(1, 7'h03, 8'h00); acc(1, 7'h04, 8'h83);
    acc(1, 7'h00, 8'h20);                                   // status via window
    acc(0, 7'h03, 0);     chk("R4 window to status", got_d, 8'h20);
    acc(1, 7'h03, 8'h00);
  endtask

  task automatic t_self;
    acc(1, 7'h04, 8'h00);
    acc(0, 7'h00, 0);     chk("R7 self read", got_d, 0);
    chk("R7 self addr", got_a, 9'h000);
    acc(1, 7'h00, 8'h99);
    acc(0, 7'h04, 0);     chk("R7 pointer unchanged", got_d, 8'h00);
    acc(0, 7'h03, 0);     chk("R7 status unchanged", got_d, 8'h00);
    acc(0, 7'h30, 0);     chk("R7 array unchanged", got_d, 8'h77);
    acc(1, 7'h04, 8'h80);
    acc(0, 7'h00, 0);     chk("R7 self read bank1", got_d, 0);
  endtask

  task automatic t_mirror;
    for (int b = 0; b < 4; b++) begin
      acc(1, 7'h03, 8'(b << 5));
      acc(1, 7'h04, 8'(8'hC0 + b));
      acc(0, 7'h04, 0);   chk("R6 pointer in bank", got_d, 8'hC0 + b);
      acc(0, 7'h03, 0);   chk("R6 status in bank", got_d, b << 5);
    end
    acc(1, 7'h03, 8'hFF); acc(0, 7'h03, 0); chk("R6 all status bits", got_d, 8'hFF);
    acc(1, 7'h03, 8'h00);
  endtask

  task automatic t_readfirst;
    acc(1, 7'h40, 8'h11);
    chk("R9 valid", got_v, 1);
    acc(1, 7'h40, 8'h22); chk("R9 array read-first", got_d, 8'h11);
    acc(0, 7'h40, 0);     chk("R9 array new value", got_d, 8'h22);
    acc(1, 7'h04, 8'h55); acc(1, 7'h04, 8'h66);
    chk("R9 register read-first", got_d, 8'h55);
    @(negedge clk);
    chk("R9 idle no valid", rd_valid, 0);
    chk("R9 idle data zero", rd_data, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog got=0x0 exp=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_direct();
    t_indirect();
    t_self();
    t_mirror();
    t_readfirst();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule